// File: doc/BRIEF.md
# Rendezvous Neighbor Port Mesh

This block joins a rectangular grid of processing nodes through unbuffered word channels, one channel on each edge between two adjacent nodes. A node sends or receives a word with a single access: it raises a read or a write strobe for one cycle, together with a four-bit direction mask and, for a write, the data word. The node then sleeps until a neighbor performs the opposite access on the same shared edge. The word crosses in that cycle. Both nodes get a one-cycle `done` pulse and wake together. Either end of an edge may act as the writer. The channel stores nothing beyond the word that the sleeping writer has already latched.

A mask with several bits set addresses several neighbors at once. A multi-direction read takes its word from whichever selected neighbor is writing toward it. A multi-direction write hands its word to exactly one selected reader. Where several partners are ready in the same cycle, a fixed priority decides: Right, then Down, then Left, then Up. When both ends of an edge write, or both read, nothing matches and both ends stay asleep. There is no error and no timeout. Reset is the only way out of such a stall.

Each node runs a three-state machine. IDLE moves to PEND_RD on an accepted read strobe, and to PEND_WR on an accepted write strobe. A pending state returns to IDLE on the edge where its transfer completes (transition XFER). While a node is pending it takes no notice of strobes (transition HOLD).

Top module: `rvp_mesh`

## Requirements
- R1: After reset every node is in IDLE, with `node_sleep`, `node_done` and `node_rdata` all zero.
- R2: A strobe accepted in IDLE sets the node's sleep output on the next edge. A strobe is accepted when exactly one of read or write is set and the mask is nonzero. Sleep stays set until that node's transfer completes.
- R3: Suppose a write is pending on an edge and a read is pending at the other end of it. On the next clock edge both nodes pulse done and both drop sleep. The reader's `node_rdata` then equals the writer's word.
- R4: Transfers work in both directions on every horizontal and vertical edge. Mask bit 3 is Right (column+1), bit 2 is Down (row+1), bit 1 is Left (column-1) and bit 0 is Up (row-1). Node index is row*COLS+column.
- R5: A write's data is captured from `node_wdata` when the strobe is accepted. Later changes on `node_wdata` during the wait do not alter the word delivered.
- R6: Suppose a multi-direction read faces several writers that are pending toward it. It takes the word from the highest-priority one, in the order Right > Down > Left > Up. The other writers stay asleep.
- R7: Suppose a multi-direction write faces several readers that are pending toward it. Only the highest-priority reader, in the order Right > Down > Left > Up, receives the word. The others stay asleep. A multi-direction write also completes when only one selected neighbor reads.
- R8: Two writes on the same edge never transfer, and neither do two reads on the same edge. Both nodes stay asleep with done low.
- R9: A node ignores strobes while it is pending. In IDLE it also ignores a strobe that has both read and write set, and a strobe that has a zero mask.
- R10: An access whose only selected directions lead off the edge of the grid never completes.
- R11: `node_done` is a one-cycle pulse. A node's `node_rdata` changes only when that node completes a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | NODES*4 | Direction mask for each node, bits 3..0 = R, D, L, U |
| node_rd | input | NODES | One-cycle read strobe for each node |
| node_wr | input | NODES | One-cycle write strobe for each node |
| node_wdata | input | NODES*WIDTH | Write word for each node, sampled with the strobe |
| node_rdata | output | NODES*WIDTH | Last word each node received |
| node_done | output | NODES | One-cycle pulse when a node's access completes |
| node_sleep | output | NODES | High while a node waits on an access |

## Verification
The assertions assume that a node pulses a strobe only while its sleep output is low. They also assume that the strobe lasts exactly one cycle, so each access begins from IDLE. The stimulus follows this rule. It raises strobes at the falling edge, clears them at the next falling edge, and issues a new access only after the previous one has finished or after a reset. The one exception is the deliberate extra strobe sent to a sleeping node to test R9. The design ignores that strobe, which the hold assertion tolerates. Stalls that never resolve, such as same-kind pairs and accesses aimed off the grid, are always cleared with a reset before the next test.

// File: rtl/rvp_pkg.sv
package rvp_pkg;

    localparam int NDIR  = 4;
    localparam int DIR_U = 0;
    localparam int DIR_L = 1;
    localparam int DIR_D = 2;
    localparam int DIR_R = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND_RD = 2'd1,
        ST_PEND_WR = 2'd2
    } port_st_e;

    // Opposite compass direction: R<->L, D<->U.
    function automatic int opp_dir(input int d);
        return d ^ 2;
    endfunction

    function automatic bit nb_valid(input int node, input int d,
                                    input int rows, input int cols);
        int r;
        int c;
        r = node / cols;
        c = node % cols;
        unique case (d)
            DIR_R:   return (c + 1) < cols;
            DIR_L:   return c > 0;
            DIR_D:   return (r + 1) < rows;
            default: return r > 0;
        endcase
    endfunction

    function automatic int nb_index(input int node, input int d, input int cols);
        unique case (d)
            DIR_R:   return node + 1;
            DIR_L:   return node - 1;
            DIR_D:   return node + cols;
            default: return node - cols;
        endcase
    endfunction

endpackage

// File: rtl/rvp_pick.sv
module rvp_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Highest index wins, so bit 3 (Right) has top priority.
    always_comb begin
        gnt = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rvp_arbiter.sv
module rvp_arbiter #(
    parameter int WIDTH = 18,
    parameter int NDIR  = 4
) (
    input  logic [NDIR-1:0]  want_rd,
    input  logic [NDIR-1:0]  want_wr,
    input  logic [NDIR-1:0]  nbr_wr,
    input  logic [NDIR-1:0]  nbr_choose,
    input  logic [NDIR-1:0]  nbr_grant,
    input  logic [WIDTH-1:0] nbr_word [NDIR],
    output logic [NDIR-1:0]  choose,
    output logic [NDIR-1:0]  grant,
    output logic [NDIR-1:0]  xfer_dir,
    output logic [WIDTH-1:0] xfer_data
);
    logic [NDIR-1:0] rd_cand;
    logic [NDIR-1:0] wr_offer;
    logic [NDIR-1:0] rd_done;

    assign rd_cand  = want_rd & nbr_wr;
    assign wr_offer = want_wr & nbr_choose;

    rvp_pick #(.N(NDIR)) u_rd_pick (.req(rd_cand),  .gnt(choose));
    rvp_pick #(.N(NDIR)) u_wr_pick (.req(wr_offer), .gnt(grant));

    assign rd_done  = choose & nbr_grant;
    assign xfer_dir = rd_done | grant;

    always_comb begin
        xfer_data = '0;
        for (int d = 0; d < NDIR; d++) begin
            if (rd_done[d]) xfer_data = xfer_data | nbr_word[d];
        end
    end
endmodule

// File: rtl/rvp_node_fsm.sv
module rvp_node_fsm
    import rvp_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDIR-1:0]  acc_mask,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [WIDTH-1:0] acc_wdata,
    input  logic [NDIR-1:0]  xfer_dir,
    input  logic [WIDTH-1:0] xfer_data,
    output logic [NDIR-1:0]  want_rd,
    output logic [NDIR-1:0]  want_wr,
    output logic [WIDTH-1:0] word_q,
    output logic [WIDTH-1:0] rdata,
    output logic             done,
    output logic             sleep
);
    port_st_e        state, state_nx;
    logic [NDIR-1:0] mask_q;
    logic            accept;
    logic            xfer_any;

    assign accept   = (acc_rd ^ acc_wr) && (acc_mask != '0);
    assign xfer_any = |xfer_dir;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = acc_wr ? ST_PEND_WR : ST_PEND_RD;
            end
            ST_PEND_RD, ST_PEND_WR: begin
                if (xfer_any) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mask_q <= '0;
            word_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && accept) begin
                mask_q <= acc_mask;
                word_q <= acc_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (state != ST_IDLE) && xfer_any;
            if (state == ST_PEND_RD && xfer_any) rdata <= xfer_data;
        end
    end

    assign want_rd = (state == ST_PEND_RD) ? mask_q : '0;
    assign want_wr = (state == ST_PEND_WR) ? mask_q : '0;
    assign sleep   = (state != ST_IDLE);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    wake_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> done);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !xfer_any) |=> (sleep && $stable(mask_q)));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND_WR && !xfer_any) |=> $stable(word_q));

    // R11
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));
endmodule

// File: rtl/rvp_mesh.sv
module rvp_mesh
    import rvp_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 2,
    parameter int WIDTH = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ROWS*COLS*4-1:0]   node_addr,
    input  logic [ROWS*COLS-1:0]     node_rd,
    input  logic [ROWS*COLS-1:0]     node_wr,
    input  logic [ROWS*COLS*WIDTH-1:0] node_wdata,
    output logic [ROWS*COLS*WIDTH-1:0] node_rdata,
    output logic [ROWS*COLS-1:0]     node_done,
    output logic [ROWS*COLS-1:0]     node_sleep
);
    localparam int NODES = ROWS * COLS;

    logic [NDIR-1:0]  want_rd    [NODES];
    logic [NDIR-1:0]  want_wr    [NODES];
    logic [NDIR-1:0]  choose     [NODES];
    logic [NDIR-1:0]  grant      [NODES];
    logic [NDIR-1:0]  xfer_dir   [NODES];
    logic [WIDTH-1:0] xfer_data  [NODES];
    logic [WIDTH-1:0] word_q     [NODES];
    logic [NDIR-1:0]  nbr_wr     [NODES];
    logic [NDIR-1:0]  nbr_choose [NODES];
    logic [NDIR-1:0]  nbr_grant  [NODES];
    logic [WIDTH-1:0] nbr_word   [NODES][NDIR];

    for (genvar n = 0; n < NODES; n++) begin : g_node
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            if (nb_valid(n, d, ROWS, COLS)) begin : g_link
                localparam int M  = nb_index(n, d, COLS);
                localparam int OD = opp_dir(d);
                assign nbr_wr[n][d]     = want_wr[M][OD];
                assign nbr_choose[n][d] = choose[M][OD];
                assign nbr_grant[n][d]  = grant[M][OD];
                assign nbr_word[n][d]   = word_q[M];
            end else begin : g_edge
                assign nbr_wr[n][d]     = 1'b0;
                assign nbr_choose[n][d] = 1'b0;
                assign nbr_grant[n][d]  = 1'b0;
                assign nbr_word[n][d]   = '0;
            end
        end

        rvp_arbiter #(.WIDTH(WIDTH), .NDIR(NDIR)) u_arb (
            .want_rd    (want_rd[n]),
            .want_wr    (want_wr[n]),
            .nbr_wr     (nbr_wr[n]),
            .nbr_choose (nbr_choose[n]),
            .nbr_grant  (nbr_grant[n]),
            .nbr_word   (nbr_word[n]),
            .choose     (choose[n]),
            .grant      (grant[n]),
            .xfer_dir   (xfer_dir[n]),
            .xfer_data  (xfer_data[n])
        );

        rvp_node_fsm #(.WIDTH(WIDTH)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_mask  (node_addr[n*4 +: 4]),
            .acc_rd    (node_rd[n]),
            .acc_wr    (node_wr[n]),
            .acc_wdata (node_wdata[n*WIDTH +: WIDTH]),
            .xfer_dir  (xfer_dir[n]),
            .xfer_data (xfer_data[n]),
            .want_rd   (want_rd[n]),
            .want_wr   (want_wr[n]),
            .word_q    (word_q[n]),
            .rdata     (node_rdata[n*WIDTH +: WIDTH]),
            .done      (node_done[n]),
            .sleep     (node_sleep[n])
        );

        // R3
        done_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            node_done[n] |-> $past(node_sleep[n]));
    end

    // R3
    pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(node_done) % 2) == 0);
endmodule

// File: tb/rvp_mesh_test.sv
module rvp_mesh_test;
    localparam int W = 18;
    localparam int N = 4;

    typedef struct packed {
        logic [1:0]   an;
        logic         aw;
        logic [3:0]   am;
        logic [W-1:0] ad;
        logic [1:0]   bn;
        logic         bw;
        logic [3:0]   bm;
        logic [W-1:0] bd;
    } vec_t;

    // Mask bits: 3=R 2=D 1=L 0=U; nodes 0 1 / 2 3.
    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b1, 4'b1000, 18'h12345, 2'd1, 1'b0, 4'b0010, 18'h00000},
        '{2'd1, 1'b1, 4'b0010, 18'h3FFFF, 2'd0, 1'b0, 4'b1000, 18'h00000},
        '{2'd0, 1'b1, 4'b0100, 18'h00001, 2'd2, 1'b0, 4'b0001, 18'h00000},
        '{2'd3, 1'b1, 4'b0001, 18'h2AAAA, 2'd1, 1'b0, 4'b0100, 18'h00000},
        '{2'd3, 1'b1, 4'b0010, 18'h15555, 2'd2, 1'b0, 4'b1000, 18'h00000},
        '{2'd2, 1'b1, 4'b1001, 18'h0ABCD, 2'd0, 1'b0, 4'b0100, 18'h00000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N*4-1:0] node_addr = '0;
    logic [N-1:0]   node_rd = '0;
    logic [N-1:0]   node_wr = '0;
    logic [N*W-1:0] node_wdata = '0;
    logic [N*W-1:0] node_rdata;
    logic [N-1:0]   node_done;
    logic [N-1:0]   node_sleep;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_rd [N];

    always #5 clk = ~clk;

    rvp_mesh #(.ROWS(2), .COLS(2), .WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .node_rd(node_rd),
        .node_wr(node_wr), .node_wdata(node_wdata), .node_rdata(node_rdata),
        .node_done(node_done), .node_sleep(node_sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rd_of(input int n);
        return node_rdata[n*W +: W];
    endfunction

    task automatic issue(input int n, input bit w, input logic [3:0] m, input logic [W-1:0] d);
        node_addr[n*4 +: 4] = m;
        node_rd[n] = ~w;
        node_wr[n] = w;
        node_wdata[n*W +: W] = d;
    endtask

    task automatic clear_strobes();
        node_rd = '0;
        node_wr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_strobes();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) exp_rd[i] = '0;
    endtask

    task automatic check_all_rdata(input string tag);
        for (int i = 0; i < N; i++) chk(tag, rd_of(i), exp_rd[i]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 sleep", node_sleep, 0);
        chk("R1 done", node_done, 0);
        check_all_rdata("R1 rdata");

        // R3 R4 R11 vector table
        for (int v = 0; v < 6; v++) begin
            int wn;
            int rn;
            wn = VECS[v].aw ? VECS[v].an : VECS[v].bn;
            rn = VECS[v].aw ? VECS[v].bn : VECS[v].an;
            issue(VECS[v].an, VECS[v].aw, VECS[v].am, VECS[v].ad);
            issue(VECS[v].bn, VECS[v].bw, VECS[v].bm, VECS[v].bd);
            @(negedge clk);
            clear_strobes();
            chk("R2 sleep writer", node_sleep[wn], 1);
            chk("R2 sleep reader", node_sleep[rn], 1);
            @(negedge clk);
            exp_rd[rn] = VECS[v].aw ? VECS[v].ad : VECS[v].bd;
            chk("R3 done writer", node_done[wn], 1);
            chk("R3 done reader", node_done[rn], 1);
            chk("R4 sleep cleared", node_sleep, 0);
            check_all_rdata("R3 R11 rdata");
            @(negedge clk);
            chk("R11 done pulse", node_done, 0);
        end

        // R5 data latched at issue
        issue(0, 1'b1, 4'b1000, 18'h0C0DE);
        @(negedge clk);
        clear_strobes();
        node_wdata[0 +: W] = 18'h3BEEF;
        repeat (3) @(negedge clk);
        chk("R5 writer waits", node_sleep[0], 1);
        issue(1, 1'b0, 4'b0010, '0);
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        exp_rd[1] = 18'h0C0DE;
        chk("R5 latched word", rd_of(1), exp_rd[1]);

        // R6 multi-direction read, L beats U
        @(negedge clk);
        issue(3, 1'b0, 4'b0011, '0);
        issue(1, 1'b1, 4'b0100, 18'h11111);
        issue(2, 1'b1, 4'b1000, 18'h22222);
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        chk("R6 reader gets L", rd_of(3), 18'h22222);
        chk("R6 L writer done", node_done[2], 1);
        chk("R6 U writer still sleeps", {node_done[1], node_sleep[1]}, 2'b01);
        issue(3, 1'b0, 4'b0001, '0);
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        chk("R6 second read from U", rd_of(3), 18'h11111);
        chk("R6 all awake", node_sleep, 0);

        // R7 multi-direction write, R beats D
        issue(0, 1'b1, 4'b1100, 18'h2F00D);
        issue(1, 1'b0, 4'b0010, '0);
        issue(2, 1'b0, 4'b0001, '0);
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        chk("R7 R reader gets word", rd_of(1), 18'h2F00D);
        chk("R7 D reader sleeps", {node_done[2], node_sleep[2]}, 2'b01);
        chk("R7 writer awake", node_sleep[0], 0);
        issue(0, 1'b1, 4'b0100, 18'h01234);
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        chk("R7 D reader later", rd_of(2), 18'h01234);

        // R8 same-kind pairs
        do_reset();
        issue(0, 1'b1, 4'b1000, 18'h1);
        issue(1, 1'b1, 4'b0010, 18'h2);
        issue(2, 1'b0, 4'b0001, '0);
        issue(3, 1'b0, 4'b0001, '0);
        issue(2, 1'b0, 4'b1000, '0);
        issue(3, 1'b0, 4'b0010, '0);
        @(negedge clk);
        clear_strobes();
        repeat (4) @(negedge clk);
        chk("R8 all stalled", node_sleep, 4'hF);
        chk("R8 no done", node_done, 0);
        check_all_rdata("R8 rdata untouched");

        // R9 strobe while pending, both-strobe and zero mask
        do_reset();
        issue(0, 1'b0, 4'b1000, '0);
        @(negedge clk);
        issue(0, 1'b1, 4'b1000, 18'h3AAAA);
        node_rd[2] = 1'b1;
        node_wr[2] = 1'b1;
        node_addr[8 +: 4] = 4'b1000;
        issue(3, 1'b0, 4'b0000, '0);
        @(negedge clk);
        clear_strobes();
        chk("R9 bad strobes ignored", {node_sleep[2], node_sleep[3]}, 2'b00);
        issue(1, 1'b1, 4'b0010, 18'h05A5A);
        @(negedge clk);
        clear_strobes();
        @(negedge clk);
        chk("R9 pending read kept", rd_of(0), 18'h05A5A);
        chk("R9 both done", {node_done[0], node_done[1]}, 2'b11);

        // R10 off-grid access
        do_reset();
        issue(0, 1'b0, 4'b0011, '0);
        issue(3, 1'b1, 4'b1100, 18'h7);
        @(negedge clk);
        clear_strobes();
        repeat (5) @(negedge clk);
        chk("R10 stall off grid", {node_sleep[0], node_sleep[3]}, 2'b11);
        chk("R10 no done", node_done, 0);
        do_reset();
        @(negedge clk);
        chk("R1 reset clears stall", node_sleep, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule